// File: doc/BRIEF.md
# Memory Ordering Group Dispatcher

This block sits at the dispatch stage of an out-of-order core. Every dispatched memory operation is placed in a dependency group under a weak ordering model, and the block returns the group identifier. For a newly opened group it also lists up to four older groups that the new group must wait on. Each of those edges is marked either as an order dependency or as a data dependency. A separate scoreboard holds the group records and their counters, and it consumes these edges. This block holds only four "latest group" registers, an identifier counter and one flag.

Three flags describe the operation: may-load, may-store and has-side-effects. A load with side effects becomes a load barrier. A store with side effects becomes a store barrier. An operation with all three flags set is a full barrier. A static configuration bit states that loads never alias stores. When it is set, loads are released from waiting on older stores.

The four predecessor slots are fixed. Slot 0 is the store-barrier edge, slot 1 the store edge, slot 2 the load-barrier edge and slot 3 the load edge. Slot k occupies bits [k*GID_W +: GID_W] of the identifier bus and bit k of the valid and data-tag buses.

Top module: `memord_group_disp`

## Requirements
- R1: Out of reset the first new group gets identifier 1. While dispatch is low, the identifier output is 0, no edge is valid and the allocate flag is low. A dispatch with neither load nor store set also gets identifier 0 and changes no state.
- R2: With side effects set, a load acts as a load barrier and a store as a store barrier; with both it acts as both. A barrier always opens a new group.
- R3: A store waits on the latest store barrier (slot 0, data tag) and on the latest store group (slot 1, data tag). Slot 1 is left invalid when it would repeat the identifier already valid in slot 0.
- R4: A store waits on the latest load group in slot 3 with the order tag (data bit 0), whatever the no-alias bit says.
- R5: A load waits on the latest store group (slot 1, data tag) only when the no-alias bit is 0.
- R6: A load waits on the latest load barrier in slot 2 with the data tag.
- R7: A plain load (no store, no side effects) joins the open load group if one exists. It then returns that group's identifier with allocate low and no edges. Any store or barrier closes the open load group.
- R8: A load barrier waits on the latest load group in slot 3 with the data tag (data bit 1). Slot 3 is left invalid when it would repeat the identifier already valid in slot 2.
- R9: Each new group takes the next identifier. After 2^GID_W-1 the count wraps to 1, so 0 is never issued.
- R10: A latest-group register that holds 0 produces no edge, and no valid edge carries identifier 0.
- R11: A flag combination presented while dispatch is low changes no state: the following dispatch gets the identifier and edges it would have had anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_disp | input | 1 | Dispatch strobe |
| i_may_ld | input | 1 | Operation may read memory |
| i_may_st | input | 1 | Operation may write memory |
| i_side_fx | input | 1 | Operation has side effects not otherwise modelled |
| i_ld_noalias | input | 1 | Loads are assumed never to alias stores |
| o_gid | output | GID_W | Assigned group identifier, 0 for none |
| o_alloc | output | 1 | A new group is opened this cycle |
| o_pred_vld | output | 4 | Valid bit per predecessor slot |
| o_pred_data | output | 4 | Per slot: 1 = data dependency, 0 = order dependency |
| o_pred_id | output | 4*GID_W | Predecessor identifiers, slot k at bits [k*GID_W +: GID_W] |

## Verification
The bench builds the block with GID_W = 3. With that width the identifier wraps from 7 back to 1 within the first ten dispatches, so the wrap is exercised in the middle of a live dependency chain. It also lets old identifiers reappear as predecessors after the wrap. The stimulus sequence is chosen so that a latest-store register and a latest-store-barrier register hold the same identifier, which exercises the duplicate suppression between slots 0 and 1. A full barrier with every slot valid follows.

// File: rtl/memord_pkg.sv
package memord_pkg;

  localparam int PRED_N   = 4;
  localparam int SLOT_STB = 0;
  localparam int SLOT_ST  = 1;
  localparam int SLOT_LDB = 2;
  localparam int SLOT_LD  = 3;

  typedef struct packed {
    logic is_ld;
    logic is_st;
    logic ld_bar;
    logic st_bar;
    logic plain_ld;
  } op_kind_t;

  function automatic op_kind_t classify(input logic ld, input logic st, input logic fx);
    op_kind_t k;
    k.is_ld    = ld;
    k.is_st    = st;
    k.ld_bar   = ld & fx;
    k.st_bar   = st & fx;
    k.plain_ld = ld & ~st & ~fx;
    return k;
  endfunction

endpackage

// File: rtl/memord_idgen.sv
module memord_idgen #(
  parameter int GID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  output logic [GID_W-1:0] next_id
);
  localparam logic [GID_W-1:0] ID_TOP = {GID_W{1'b1}};

  function automatic logic [GID_W-1:0] bump(input logic [GID_W-1:0] cur);
    return (cur == ID_TOP) ? GID_W'(1) : cur + GID_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     next_id <= GID_W'(1);
    else if (alloc) next_id <= bump(next_id);
  end

  assert_id_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    next_id != '0);
  assert_id_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> next_id != $past(next_id));
  assert_id_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(next_id));
endmodule

// File: rtl/memord_last_regs.sv
module memord_last_regs
  import memord_pkg::*;
#(
  parameter int GID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  op_kind_t         kind,
  input  logic [GID_W-1:0] new_id,
  output logic [GID_W-1:0] last_ld,
  output logic [GID_W-1:0] last_ldb,
  output logic [GID_W-1:0] last_st,
  output logic [GID_W-1:0] last_stb,
  output logic             ld_open
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ld  <= '0;
      last_ldb <= '0;
      last_st  <= '0;
      last_stb <= '0;
      ld_open  <= 1'b0;
    end else if (alloc) begin
      if (kind.is_ld)  last_ld  <= new_id;
      if (kind.ld_bar) last_ldb <= new_id;
      if (kind.is_st)  last_st  <= new_id;
      if (kind.st_bar) last_stb <= new_id;
      ld_open <= kind.plain_ld;
    end
  end

  assert_open_has_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_open |-> last_ld != '0);
endmodule

// File: rtl/memord_edges.sv
module memord_edges
  import memord_pkg::*;
#(
  parameter int GID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_kind_t                kind,
  input  logic                    noalias,
  input  logic [GID_W-1:0]        last_ld,
  input  logic [GID_W-1:0]        last_ldb,
  input  logic [GID_W-1:0]        last_st,
  input  logic [GID_W-1:0]        last_stb,
  output logic [PRED_N-1:0]       vld,
  output logic [PRED_N-1:0]       dat,
  output logic [PRED_N*GID_W-1:0] ids
);
  logic [GID_W-1:0] src [PRED_N];
  logic dup_st, dup_ld;

  always_comb begin
    src[SLOT_STB] = last_stb;
    src[SLOT_ST]  = last_st;
    src[SLOT_LDB] = last_ldb;
    src[SLOT_LD]  = last_ld;

    vld[SLOT_STB] = en & kind.is_st & (last_stb != '0);
    dup_st        = vld[SLOT_STB] & (last_st == last_stb);
    vld[SLOT_ST]  = en & (last_st != '0) & ~dup_st
                  & (kind.is_st | (kind.is_ld & ~noalias));
    vld[SLOT_LDB] = en & kind.is_ld & (last_ldb != '0);
    dup_ld        = vld[SLOT_LDB] & (last_ld == last_ldb);
    vld[SLOT_LD]  = en & (last_ld != '0) & ~dup_ld & (kind.is_st | kind.ld_bar);

    dat[SLOT_STB] = vld[SLOT_STB];
    dat[SLOT_ST]  = vld[SLOT_ST];
    dat[SLOT_LDB] = vld[SLOT_LDB];
    dat[SLOT_LD]  = vld[SLOT_LD] & kind.ld_bar;
  end

  for (genvar k = 0; k < PRED_N; k++) begin : g_pack
    assign ids[k*GID_W +: GID_W] = vld[k] ? src[k] : '0;
  end

  assert_no_dup_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[SLOT_STB] && vld[SLOT_ST]) |-> ids[SLOT_STB*GID_W +: GID_W] != ids[SLOT_ST*GID_W +: GID_W]);
  assert_alias_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind.is_ld && !kind.is_st && noalias) |-> !vld[SLOT_ST]);
  assert_store_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind.is_st && !kind.ld_bar && vld[SLOT_LD]) |-> !dat[SLOT_LD]);
endmodule

// File: rtl/memord_group_disp.sv
module memord_group_disp
  import memord_pkg::*;
#(
  parameter int GID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_disp,
  input  logic                    i_may_ld,
  input  logic                    i_may_st,
  input  logic                    i_side_fx,
  input  logic                    i_ld_noalias,
  output logic [GID_W-1:0]        o_gid,
  output logic                    o_alloc,
  output logic [PRED_N-1:0]       o_pred_vld,
  output logic [PRED_N-1:0]       o_pred_data,
  output logic [PRED_N*GID_W-1:0] o_pred_id
);
  op_kind_t         kind;
  logic             mem_op, join_ev, alloc_ev;
  logic [GID_W-1:0] next_id, last_ld, last_ldb, last_st, last_stb;
  logic             ld_open;

  assign kind     = classify(i_may_ld, i_may_st, i_side_fx);
  assign mem_op   = i_disp & (i_may_ld | i_may_st);
  assign join_ev  = mem_op & kind.plain_ld & ld_open;
  assign alloc_ev = mem_op & ~join_ev;

  memord_idgen #(.GID_W(GID_W)) idgen_i (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_ev), .next_id(next_id));

  memord_last_regs #(.GID_W(GID_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_ev), .kind(kind), .new_id(next_id),
    .last_ld(last_ld), .last_ldb(last_ldb), .last_st(last_st),
    .last_stb(last_stb), .ld_open(ld_open));

  memord_edges #(.GID_W(GID_W)) edges_i (
    .clk(clk), .rst_n(rst_n), .en(alloc_ev), .kind(kind), .noalias(i_ld_noalias),
    .last_ld(last_ld), .last_ldb(last_ldb), .last_st(last_st), .last_stb(last_stb),
    .vld(o_pred_vld), .dat(o_pred_data), .ids(o_pred_id));

  assign o_alloc = alloc_ev;
  assign o_gid   = alloc_ev ? next_id : (join_ev ? last_ld : '0);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !i_disp |-> (o_gid == '0 && o_pred_vld == '0 && !o_alloc));
  assert_join_no_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_disp && !o_alloc && o_gid != '0) |-> o_pred_vld == '0);
  assert_barrier_allocs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_disp && i_side_fx && (i_may_ld || i_may_st)) |-> o_alloc);
  for (genvar k = 0; k < PRED_N; k++) begin : g_chk
    assert_edge_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      o_pred_vld[k] |-> o_pred_id[k*GID_W +: GID_W] != '0);
  end
endmodule

// File: tb/memord_group_disp_tb_top.sv
module memord_group_disp_tb_top;
  localparam int W = 3;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp = 0, ld = 0, st = 0, fx = 0, na = 0;
  logic [W-1:0]   gid;
  logic           alloc;
  logic [3:0]     pvld, pdat;
  logic [4*W-1:0] pid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memord_group_disp #(.GID_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .i_disp(disp), .i_may_ld(ld), .i_may_st(st),
    .i_side_fx(fx), .i_ld_noalias(na), .o_gid(gid), .o_alloc(alloc),
    .o_pred_vld(pvld), .o_pred_data(pdat), .o_pred_id(pid));

  // na ld st fx | gid alloc | vld dat | p0 p1 p2 p3
  localparam logic [27:0] TBL [NV] = '{
    {4'b0100, 3'd1, 1'b1, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0100, 3'd1, 1'b0, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0010, 3'd2, 1'b1, 4'b1000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd1},
    {4'b0100, 3'd3, 1'b1, 4'b0010, 4'b0010, 3'd0, 3'd2, 3'd0, 3'd0},
    {4'b1100, 3'd3, 1'b0, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0010, 3'd4, 1'b1, 4'b1010, 4'b0010, 3'd0, 3'd2, 3'd0, 3'd3},
    {4'b1100, 3'd5, 1'b1, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0101, 3'd6, 1'b1, 4'b1010, 4'b1010, 3'd0, 3'd4, 3'd0, 3'd5},
    {4'b0100, 3'd7, 1'b1, 4'b0110, 4'b0110, 3'd0, 3'd4, 3'd6, 3'd0},
    {4'b0011, 3'd1, 1'b1, 4'b1010, 4'b0010, 3'd0, 3'd4, 3'd0, 3'd7},
    {4'b0010, 3'd2, 1'b1, 4'b1001, 4'b0001, 3'd1, 3'd0, 3'd0, 3'd7},
    {4'b1111, 3'd3, 1'b1, 4'b1111, 4'b1111, 3'd1, 3'd2, 3'd6, 3'd7},
    {4'b0100, 3'd4, 1'b1, 4'b0110, 4'b0110, 3'd0, 3'd3, 3'd3, 3'd0},
    {4'b0001, 3'd0, 1'b0, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0100, 3'd4, 1'b0, 4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0},
    {4'b0010, 3'd5, 1'b1, 4'b1001, 4'b0001, 3'd3, 3'd0, 3'd0, 3'd4}
  };

  function automatic string row_req(input int i);
    case (i)
      0: return "R1 first group";      1: return "R7 join";
      2: return "R4 store after load"; 3: return "R5 load after store";
      4: return "R7 join noalias";     5: return "R3 store chain";
      6: return "R5 noalias load";     7: return "R8 load barrier";
      8: return "R6 wait barrier";     9: return "R9 wrap store barrier";
      10: return "R3 dup suppress";    11: return "R2 full barrier";
      12: return "R10 dup ids";        13: return "R1 non-memory";
      14: return "R7 rejoin";          default: return "R3 store after full";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] eg, input logic ea,
                       input logic [3:0] ev, input logic [3:0] ed, input logic [4*W-1:0] ep);
    logic ok;
    ok = (gid === eg) && (alloc === ea) && (pvld === ev) && ((pdat & ev) === ed);
    for (int k = 0; k < 4; k++)
      if (ev[k] && pid[k*W +: W] !== ep[k*W +: W]) ok = 0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got gid=%0d alloc=%0b vld=%b dat=%b ids=%h, expected gid=%0d alloc=%0b vld=%b dat=%b ids=%h",
               req, gid, alloc, pvld, pdat, pid, eg, ea, ev, ed, ep);
    end
  endtask

  task automatic drive(input logic v, input logic a, input logic l, input logic s, input logic f);
    @(negedge clk);
    disp = v; na = a; ld = l; st = s; fx = f;
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(0, 0, 1, 0, 0);
    check("R1 reset idle", 0, 0, 4'b0, 4'b0, '0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      logic [27:0] e;
      e = TBL[i];
      drive(1, e[27], e[26], e[25], e[24]);
      check(row_req(i), e[23:21], e[20], e[19:16], e[15:12],
            {e[2:0], e[5:3], e[8:6], e[11:9]});
    end
    // R11: flags with strobe low, then a load must see untouched state
    drive(0, 0, 0, 1, 1);
    check("R11 strobe low", 0, 0, 4'b0, 4'b0, '0);
    drive(1, 0, 1, 0, 0);
    check("R11 state kept", 3'd6, 1, 4'b0110, 4'b0110, {3'd0, 3'd3, 3'd5, 3'd0});
    // mid-stream reset returns to identifier 1 with empty registers
    @(negedge clk); disp = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    drive(1, 0, 1, 0, 0);
    check("R10 empty regs after reset", 3'd1, 1, 4'b0, 4'b0, '0);
    drive(1, 0, 0, 1, 0);
    check("R4 store order edge", 3'd2, 1, 4'b1000, 4'b0000, {3'd1, 3'd0, 3'd0, 3'd0});
    drive(1, 1, 0, 1, 0);
    check("R4 store with noalias", 3'd3, 1, 4'b1010, 4'b0010, {3'd1, 3'd0, 3'd2, 3'd0});
    drive(0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule